// File: doc/BRIEF.md
# Single-Bit Register Test and Modify Unit

This is the execute-stage logic that carries out single-bit instructions against one 32-bit register operand. It receives a 32-bit instruction word, the destination register value and a register value for the S operand. It produces a register write (address, data and enable) in the same cycle, and it holds the carry (C) and zero (Z) flags, which are updated on the clock edge. Register storage, fetch and pipelining belong to the surrounding core.

One block of eight opcodes serves two instruction families. The two flag-select bits decide which family applies. When exactly one of them is set, the instruction is a flag test: the addressed bit, or its inverse, is moved into the chosen flag or combined into it with AND, OR or XOR. When both or neither are set, the instruction is a bit write. The write clears, sets, copies a flag, copies an inverted flag, loads a random bit or inverts the addressed bit. When both select bits are set, the write also returns the old bit in C and its inverse in Z. A 4-bit condition field, evaluated against the current flags, gates all of it.

Top module: `bitop_unit`

## Requirements
- R1: The instruction word holds the condition in bits [31:28], the opcode in [27:21], the C select in [20], the Z select in [19], the immediate select in [18], the D field in [17:9] and the S field in [8:0]. Only opcodes 0100000 to 0100111 act. Any other opcode gives no write and leaves both flags unchanged.
- R2: With bit [18] at 1, the S operand is the 9-bit S field itself. With bit [18] at 0, it is `s_reg_val`. The bit index is the low 5 bits of the S operand, and the upper bits have no effect.
- R3: The instruction executes only when bit number {C,Z} of the condition field (C as the high index bit) is 1. So 0000 never executes, 1111 always does, 1100 needs C, 0011 needs !C, 1010 needs Z, 0101 needs !Z and 0110 needs C != Z. A failed condition writes nothing and changes no flag.
- R4: With exactly one select bit set, the instruction is a test. Opcode bits [2:1] choose copy (00), AND (01), OR (10) or XOR (11) into the flag. Opcode bit [0] at 1 uses the inverted bit. Select [20] targets C and select [19] targets Z. The other flag does not change.
- R5: A test instruction never asserts `wr_en`.
- R6: With both or neither select bits set, the instruction is a write. Opcode bits [2:0] = 0 to 7 make the bit 0, 1, C, !C, Z, !Z, `rnd_bit` or !bit. `wr_en` is high in the cycle of each executed write, and only then. `wr_addr` is the D field, and `wr_data` differs from `d_val` in the addressed bit at most.
- R7: A write with both select bits set loads C with the bit's old value and Z with its inverse. A write with neither select bit set leaves both flags unchanged.
- R8: The condition and the flag sources of a write use the flag values from before the instruction's own flag update.
- R9: After reset both flags are 0, and `wr_en` is 0 while `exec_en` is low.
- R10: `rnd_bit` is used in the same cycle that the random-bit write executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| d_val | input | 32 | Destination register value |
| s_reg_val | input | 32 | Register value addressed by S |
| rnd_bit | input | 1 | Random bit source |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | 9 | Register write address (D field) |
| wr_data | output | 32 | Updated register value |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
Two things can happen in the same cycle: a write that takes its new bit from C or Z, and a capture that overwrites both flags with the old bit. The bench combines every write opcode with both select bits set across all four starting flag states. It checks that `wr_data` reflects the flags from before the edge and that, after the edge, the flags hold the old bit and its inverse. The condition check, which reads the flags that the same instruction may then change, is swept over all 16 codes and all four flag states.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned FIELD_W = 9;
  localparam logic [3:0]  OPC_GROUP = 4'b0100;

  typedef struct packed {
    logic [3:0]         cond;
    logic [6:0]         opc;
    logic               sel_c;
    logic               sel_z;
    logic               imm;
    logic [FIELD_W-1:0] dfld;
    logic [FIELD_W-1:0] sfld;
  } instr_t;

  typedef enum logic [1:0] {
    FAM_NONE  = 2'b00,
    FAM_TEST  = 2'b01,
    FAM_WRITE = 2'b10
  } fam_e;

  typedef enum logic [1:0] {
    TF_MOV = 2'b00,
    TF_AND = 2'b01,
    TF_OR  = 2'b10,
    TF_XOR = 2'b11
  } test_fn_e;
endpackage

// File: rtl/bitop_rst_sync.sv
module bitop_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bitop_cond.sv
module bitop_cond (
  input  logic [3:0] cond,
  input  logic       cur_c,
  input  logic       cur_z,
  output logic       pass
);
  // Condition field is a truth table indexed by the current {C,Z}.
  always_comb begin
    pass = cond[{cur_c, cur_z}];
  end
endmodule

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [6:0] opc,
  input  logic       sel_c,
  input  logic       sel_z,
  output fam_e       fam,
  output test_fn_e   test_fn,
  output logic       test_inv,
  output logic       tgt_c,
  output logic       capture
);
  logic in_group;

  always_comb begin
    in_group = (opc[6:3] == OPC_GROUP);
    fam      = FAM_NONE;
    if (in_group) begin
      if (sel_c ^ sel_z) fam = FAM_TEST;
      else               fam = FAM_WRITE;
    end
    test_fn  = test_fn_e'(opc[2:1]);
    test_inv = opc[0];
    tgt_c    = sel_c;
    capture  = sel_c & sel_z;
  end
endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d_val,
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        wsel,
  input  logic              cur_c,
  input  logic              cur_z,
  input  logic              rnd_bit,
  output logic              old_bit,
  output logic [DATA_W-1:0] new_word
);
  logic new_bit;

  always_comb begin
    old_bit = d_val[idx];
    unique case (wsel)
      3'd0: new_bit = 1'b0;
      3'd1: new_bit = 1'b1;
      3'd2: new_bit = cur_c;
      3'd3: new_bit = ~cur_c;
      3'd4: new_bit = cur_z;
      3'd5: new_bit = ~cur_z;
      3'd6: new_bit = rnd_bit;
      default: new_bit = ~old_bit;
    endcase
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign new_word[k] = (idx == IDX_W'(k)) ? new_bit : d_val[k];
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  d_val,
  input  logic [DATA_W-1:0]  s_reg_val,
  input  logic               rnd_bit,
  output logic               wr_en,
  output logic [FIELD_W-1:0] wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               flag_c,
  output logic               flag_z
);
  instr_t     ins;
  logic       rst_sync_n;
  logic       pass;
  fam_e       fam;
  test_fn_e   test_fn;
  logic       test_inv, tgt_c, capture;
  logic [IDX_W-1:0] idx;
  logic       old_bit;
  logic       go;
  logic       flag_ce;
  logic       c_nx, z_nx;
  logic       tval, fsrc, fres;
  logic       c_q, z_q;

  assign ins = instr_t'(instr);

  bitop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bitop_cond u_cond (
    .cond(ins.cond), .cur_c(c_q), .cur_z(z_q), .pass(pass)
  );

  bitop_decode u_dec (
    .opc(ins.opc), .sel_c(ins.sel_c), .sel_z(ins.sel_z),
    .fam(fam), .test_fn(test_fn), .test_inv(test_inv),
    .tgt_c(tgt_c), .capture(capture)
  );

  // Bit index from the immediate field or the S register value.
  always_comb begin
    idx = ins.imm ? ins.sfld[IDX_W-1:0] : s_reg_val[IDX_W-1:0];
  end

  bitop_datapath #(.DATA_W(DATA_W)) u_dp (
    .d_val(d_val), .idx(idx), .wsel(ins.opc[2:0]),
    .cur_c(c_q), .cur_z(z_q), .rnd_bit(rnd_bit),
    .old_bit(old_bit), .new_word(wr_data)
  );

  assign go      = exec_en & pass;
  assign wr_en   = go & (fam == FAM_WRITE);
  assign wr_addr = ins.dfld;

  // Flag next-state.
  always_comb begin
    c_nx = c_q;
    z_nx = z_q;
    tval = old_bit ^ test_inv;
    fsrc = tgt_c ? c_q : z_q;
    unique case (test_fn)
      TF_MOV: fres = tval;
      TF_AND: fres = fsrc & tval;
      TF_OR:  fres = fsrc | tval;
      default: fres = fsrc ^ tval;
    endcase
    if (fam == FAM_TEST) begin
      if (tgt_c) c_nx = fres;
      else       z_nx = fres;
    end else if (fam == FAM_WRITE && capture) begin
      c_nx = old_bit;
      z_nx = ~old_bit;
    end
  end

  assign flag_ce = go & (fam != FAM_NONE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (flag_ce) begin
      c_q <= c_nx;
      z_q <= z_nx;
    end
  end

  assign flag_c = c_q;
  assign flag_z = z_q;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_q,
  input logic              exec_en,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] d_val,
  input logic [DATA_W-1:0] s_reg_val,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              flag_c,
  input logic              flag_z
);
  localparam int unsigned IW = $clog2(DATA_W);
  logic          grp, sc, sz;
  logic [IW-1:0] bidx;
  logic          obit;

  assign grp  = (instr[27:24] == 4'b0100);
  assign sc   = instr[20];
  assign sz   = instr[19];
  assign bidx = instr[18] ? instr[IW-1:0] : s_reg_val[IW-1:0];
  assign obit = d_val[bidx];

  assert_out_of_group_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (exec_en && !grp) |=> ($stable(flag_c) && $stable(flag_z)));

  assert_never_cond_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (exec_en && instr[31:28] == 4'b0000) |-> !wr_en);

  assert_never_hold_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (exec_en && instr[31:28] == 4'b0000) |=> ($stable(flag_c) && $stable(flag_z)));

  assert_test_other_flag_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (exec_en && grp && sc && !sz) |=> $stable(flag_z));

  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (exec_en && grp && (sc != sz)) |-> !wr_en);

  assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en |-> ($countones(wr_data ^ d_val) <= 1));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (exec_en && grp && sc && sz && instr[31:28] == 4'b1111)
      |=> (flag_c == $past(obit) && flag_z == !$past(obit)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !exec_en |-> !wr_en);
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_q(rst_sync_n), .exec_en(exec_en), .instr(instr),
  .d_val(d_val), .s_reg_val(s_reg_val), .wr_en(wr_en), .wr_data(wr_data),
  .flag_c(flag_c), .flag_z(flag_z)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_en;
  logic [31:0] instr, d_val, s_reg_val;
  logic        rnd_bit;
  logic        wr_en;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;
  logic        flag_c, flag_z;

  int   n_chk = 0;
  int   n_fail = 0;
  logic mc = 1'b0, mz = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
    .d_val(d_val), .s_reg_val(s_reg_val), .rnd_bit(rnd_bit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  task automatic chk(input logic ok, input string tag, input string ctx,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] cnd, input logic [6:0] opc,
                     input logic sc, input logic sz, input logic im,
                     input logic [8:0] dfl, input logic [8:0] sfl,
                     input logic [31:0] dv, input logic [31:0] sr,
                     input string ctx);
    logic [4:0]  idx;
    logic        ob, ps, grp, istest, iswr, nb, tv, f, r, ec, ez;
    logic [31:0] ew;
    string       tag;
    @(negedge clk);
    instr     = {cnd, opc, sc, sz, im, dfl, sfl};
    d_val     = dv;
    s_reg_val = sr;
    rnd_bit   = lfsr[0];
    exec_en   = 1'b1;
    idx    = im ? sfl[4:0] : sr[4:0];
    ob     = dv[idx];
    ps     = cnd[{mc, mz}];
    grp    = (opc >= 7'b0100000) && (opc <= 7'b0100111);
    istest = (sc != sz);
    iswr   = grp && ps && !istest;
    ew = dv;
    if (iswr) begin
      case (opc[2:0])
        3'd0: nb = 1'b0;
        3'd1: nb = 1'b1;
        3'd2: nb = mc;
        3'd3: nb = !mc;
        3'd4: nb = mz;
        3'd5: nb = !mz;
        3'd6: nb = lfsr[0];
        default: nb = !ob;
      endcase
      ew[idx] = nb;
    end
    ec = mc; ez = mz;
    if (grp && ps && istest) begin
      tv = opc[0] ? !ob : ob;
      f  = sc ? mc : mz;
      case (opc[2:1])
        2'b00: r = tv;
        2'b01: r = f && tv;
        2'b10: r = f || tv;
        default: r = f != tv;
      endcase
      if (sc) ec = r; else ez = r;
    end
    if (iswr && sc && sz) begin
      ec = ob; ez = !ob;
    end
    if (!grp) tag = "R1";
    else if (!ps) tag = "R3";
    else if (istest) tag = "R5";
    else tag = "R6";
    #1;
    chk(wr_en == iswr, tag, {ctx, " wr_en"}, 32'(wr_en), 32'(iswr));
    if (iswr) begin
      chk(wr_data == ew, "R6", {ctx, " data"}, wr_data, ew);
      chk(wr_addr == dfl, "R6", {ctx, " addr"}, 32'(wr_addr), 32'(dfl));
    end
    @(posedge clk);
    #1;
    exec_en = 1'b0;
    if (!grp) tag = "R1";
    else if (!ps) tag = "R3";
    else if (istest) tag = "R4";
    else tag = "R7";
    chk({flag_c, flag_z} == {ec, ez}, tag, {ctx, " flags"},
        32'({flag_c, flag_z}), 32'({ec, ez}));
    mc = ec; mz = ez;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic set_flags(input logic c, input logic z);
    run(4'hF, 7'b0100000, 1'b1, 1'b0, 1'b1, 9'd0, 9'd0, {31'd0, c}, 32'd0, "R4 loadC");
    run(4'hF, 7'b0100000, 1'b0, 1'b1, 1'b1, 9'd0, 9'd0, {31'd0, z}, 32'd0, "R4 loadZ");
  endtask

  initial begin
    rst_n = 1'b0; exec_en = 1'b0; instr = '0; d_val = '0; s_reg_val = '0; rnd_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R9: reset state
    chk({flag_c, flag_z} == 2'b00, "R9", "reset flags", 32'({flag_c, flag_z}), 32'd0);
    chk(wr_en == 1'b0, "R9", "idle wr_en", 32'(wr_en), 32'd0);

    // Main sweep: R2 (imm/reg index), R4..R8, R10 (random bit)
    for (int fl = 0; fl < 4; fl++) begin
      for (int op = 0; op < 8; op++) begin
        for (int cz = 0; cz < 4; cz++) begin
          for (int b = 0; b < 3; b++) begin
            logic [4:0]  bi;
            logic [31:0] dv;
            bi = (b == 0) ? 5'd0 : (b == 1) ? 5'd31 : 5'd13;
            dv = 32'hA5C3_0F96 ^ {lfsr, lfsr};
            set_flags(fl[1], fl[0]);
            if (b[0])
              run(4'hF, {4'b0100, op[2:0]}, cz[1], cz[0], 1'b1, 9'(op + 5),
                  {4'b1011, bi}, dv, 32'hFFFF_FFFF, "R2 R8 R10 imm");
            else
              run(4'hF, {4'b0100, op[2:0]}, cz[1], cz[0], 1'b0, 9'(op + 5),
                  9'h1FF, dv, {lfsr, 11'h7FF, bi}, "R2 R8 R10 reg");
          end
        end
      end
    end

    // R3: every condition code against every flag state
    for (int cd = 0; cd < 16; cd++) begin
      for (int fl = 0; fl < 4; fl++) begin
        set_flags(fl[1], fl[0]);
        run(4'(cd), 7'b0100111, 1'b0, 1'b0, 1'b1, 9'd7, 9'd3, 32'h0000_00F0, 32'd0, "R3 cond");
        set_flags(fl[1], fl[0]);
        run(4'(cd), 7'b0100010, 1'b1, 1'b1, 1'b1, 9'd7, 9'd5, 32'h0000_0020, 32'd0, "R3 cond capture");
      end
    end

    // R1: opcodes outside the group do nothing
    for (int k = 0; k < 5; k++) begin
      logic [6:0] bad;
      bad = (k == 0) ? 7'b0000000 : (k == 1) ? 7'b0101000 : (k == 2) ? 7'b0011111 :
            (k == 3) ? 7'b1100111 : 7'b0110001;
      set_flags(1'b1, 1'b0);
      run(4'hF, bad, 1'b1, 1'b1, 1'b1, 9'd2, 9'd4, 32'h0000_0010, 32'd0, "R1 outside");
      run(4'hF, bad, 1'b0, 1'b1, 1'b1, 9'd2, 9'd4, 32'h0000_0010, 32'd0, "R1 outside test");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule